// File: doc/BRIEF.md
# Delayed Transaction Retry Controller

This block makes the target-side decision for a bus bridge. Each request that reaches it gets one of three answers: accepted, completed, or retried. Delayed reads and delayed writes are held in a small in-order queue. Each entry is tagged with its address, command and direction. A new delayed request is forwarded to the far side and the initiator is retried. When the initiator repeats the request after its completion has come back, and that entry is the oldest in the queue, the block signals completion and frees the entry.

Posted writes bypass the queue. They are accepted when the posted buffer reports room for an address and one data word. Several global conditions force a retry and leave the queue untouched:

- a locked sequence is in flight;
- the target bus is locked;
- an acceptance estimate exceeds the clock limit;
- prefetched read data is being discarded (reads only).

All answers appear one cycle after the request, together with a cause mask that reports every retry reason at once.

Top module: `dly_retry_ctl`

## Requirements
- R1: Exactly one of `rsp_accept`, `rsp_complete`, `rsp_retry` is high in the cycle after a cycle with `req_valid` high, and none of them is high otherwise. A retry always carries a non-zero `rsp_cause`. Request kinds are encoded as 00 = delayed read, 01 = delayed write, 1x = posted write.
- R2: A delayed request that matches no entry, with the queue not full and no blocking condition, is stored. It is answered with a retry carrying cause bit 0, and it is forwarded on `fwd_valid`/`fwd_addr`/`fwd_cmd`/`fwd_write` in the same cycle as the response.
- R3: A delayed request matching a stored entry (same address, command and direction) whose completion has not arrived is retried with cause bit 1. It is not forwarded and not stored again. A request that differs only in command is a different entry.
- R4: A request matching an entry whose completion has arrived, but which is not the oldest entry, is retried with cause bit 2.
- R5: A delayed read matching the completed oldest entry is retried with cause bit 3 while `posted_pending` is high. Delayed writes ignore `posted_pending`.
- R6: A request matching the completed oldest entry, with R5 not applying, is answered with `rsp_complete` and an all-zero cause. The entry is freed, so a later identical request is treated as new.
- R7: With DEPTH entries stored, a new non-matching delayed request is retried with cause bit 4 and is not forwarded or stored.
- R8: Any request is retried with cause bit 5 when `lock_active` is high and `req_lock` is low, or when `req_lock` and `tgt_bus_locked` are both high. The queue is then not touched.
- R9: Any request with `accept_est` greater than ACC_LIMIT (16) is retried with cause bit 6, and the queue is not touched.
- R10: A delayed read is retried with cause bit 7 while `prefetch_discard` is high, and the queue is not touched. Writes ignore it. When any of bits 5 to 7 is set, bits 0 to 4 are clear.
- R11: A posted write is accepted when `pw_space` is at least 2 and neither R8 nor R9 applies. Otherwise it is retried, with cause bit 8 set exactly when `pw_space` is below 2.
- R12: Each `cpl_valid` pulse marks the oldest stored entry that has not yet completed.
- R13: During and right after reset the queue is empty and all response and forward outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 00 delayed read, 01 delayed write, 1x posted write |
| req_addr | input | AW | Request address |
| req_cmd | input | CW | Request bus command |
| req_lock | input | 1 | Request belongs to a locked sequence |
| lock_active | input | 1 | A locked sequence is in progress through the bridge |
| tgt_bus_locked | input | 1 | Target bus is locked |
| prefetch_discard | input | 1 | Prefetched read data is being discarded |
| posted_pending | input | 1 | A posted write is ordered ahead of returned read data |
| pw_space | input | PWW | Free words in the posted-write buffer |
| accept_est | input | TW | Estimated clocks needed to accept the request |
| cpl_valid | input | 1 | Far side returns the next in-order completion |
| rsp_accept | output | 1 | Posted write accepted |
| rsp_complete | output | 1 | Delayed request completed, entry freed |
| rsp_retry | output | 1 | Request retried |
| rsp_cause | output | 9 | Mask of all retry reasons |
| fwd_valid | output | 1 | New delayed request forwarded to far side |
| fwd_addr | output | AW | Forwarded address |
| fwd_cmd | output | CW | Forwarded command |
| fwd_write | output | 1 | Forwarded request is a write |

## Verification
Posted writes are swept over every combination of buffer space from 0 to 4, the three lock inputs, and acceptance estimates of 15, 16 and 17. This separates the space threshold from the lock and timeout blockers, and it places the limit exactly. With the queue full, delayed reads and writes are swept over every combination of lock, timeout and discard. This shows that discard affects reads only and that any blocker masks the full cause. A directed sequence then moves entries through pending, done-but-not-oldest, held by a posted write, completed and re-entered. It also sends a request whose command differs from a stored entry, which shows that matching uses the full tag.

// File: rtl/dly_retry_ctl.sv
module dly_retry_ctl #(
  parameter int DEPTH = 4,
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int PWW = 6,
  parameter int TW = 6,
  parameter int ACC_LIMIT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_cmd,
  input  logic          req_lock,
  input  logic          lock_active,
  input  logic          tgt_bus_locked,
  input  logic          prefetch_discard,
  input  logic          posted_pending,
  input  logic [PWW-1:0] pw_space,
  input  logic [TW-1:0] accept_est,
  input  logic          cpl_valid,
  output logic          rsp_accept,
  output logic          rsp_complete,
  output logic          rsp_retry,
  output logic [8:0]    rsp_cause,
  output logic          fwd_valid,
  output logic [AW-1:0] fwd_addr,
  output logic [CW-1:0] fwd_cmd,
  output logic          fwd_write
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] q_addr [DEPTH];
  logic [CW-1:0] q_cmd  [DEPTH];
  logic [DEPTH-1:0] q_wr, q_vld, q_done;
  logic [PW-1:0] head, tail, cptr;
  logic [PW:0]   cnt;

  logic is_pw, is_wr, is_rd, full, hit;
  logic [PW-1:0] hit_idx;

  assign is_pw = req_kind[1];
  assign is_wr = !req_kind[1] && req_kind[0];
  assign is_rd = !req_kind[1] && !req_kind[0];
  assign full  = (cnt == (PW+1)'(DEPTH));

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (q_vld[i] && q_addr[i] == req_addr && q_cmd[i] == req_cmd && q_wr[i] == is_wr) begin
        hit = 1'b1;
        hit_idx = PW'(i);
      end
  end

  logic c_lock, c_time, c_disc, blk, q_ok, hit_done, hit_head;
  logic c_enter, c_pend, c_nhead, c_post, c_full, c_space, do_cpl, do_acc, cpl_ok;

  assign c_lock  = req_valid && ((lock_active && !req_lock) || (req_lock && tgt_bus_locked));
  assign c_time  = req_valid && (accept_est > TW'(ACC_LIMIT));
  assign c_disc  = req_valid && is_rd && prefetch_discard;
  assign blk     = c_lock || c_time || c_disc;
  assign q_ok    = req_valid && !is_pw && !blk;
  assign hit_done = q_done[hit_idx];
  assign hit_head = (hit_idx == head);
  assign c_enter = q_ok && !hit && !full;
  assign c_full  = q_ok && !hit && full;
  assign c_pend  = q_ok && hit && !hit_done;
  assign c_nhead = q_ok && hit && hit_done && !hit_head;
  assign c_post  = q_ok && hit && hit_done && hit_head && is_rd && posted_pending;
  assign do_cpl  = q_ok && hit && hit_done && hit_head && !(is_rd && posted_pending);
  assign c_space = req_valid && is_pw && (pw_space < PWW'(2));
  assign do_acc  = req_valid && is_pw && !blk && !c_space;
  assign cpl_ok  = cpl_valid && q_vld[cptr] && !q_done[cptr];

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_accept <= 1'b0;
      rsp_complete <= 1'b0;
      rsp_retry <= 1'b0;
      rsp_cause <= '0;
      fwd_valid <= 1'b0;
      fwd_addr <= '0;
      fwd_cmd <= '0;
      fwd_write <= 1'b0;
      head <= '0;
      tail <= '0;
      cptr <= '0;
      cnt <= '0;
      q_vld <= '0;
      q_done <= '0;
      q_wr <= '0;
    end else begin
      rsp_accept <= do_acc;
      rsp_complete <= do_cpl;
      rsp_retry <= req_valid && !do_acc && !do_cpl;
      rsp_cause <= {c_space, c_disc, c_time, c_lock, c_full, c_post, c_nhead, c_pend, c_enter};
      fwd_valid <= c_enter;
      if (c_enter) begin
        fwd_addr <= req_addr;
        fwd_cmd <= req_cmd;
        fwd_write <= is_wr;
        q_addr[tail] <= req_addr;
        q_cmd[tail] <= req_cmd;
        q_wr[tail] <= is_wr;
        q_vld[tail] <= 1'b1;
        q_done[tail] <= 1'b0;
        tail <= inc(tail);
        cnt <= cnt + 1'b1;
      end
      if (do_cpl) begin
        q_vld[head] <= 1'b0;
        head <= inc(head);
        cnt <= cnt - 1'b1;
      end
      if (cpl_ok) begin
        q_done[cptr] <= 1'b1;
        cptr <= inc(cptr);
      end
    end
  end
endmodule

module dly_retry_ctl_chk #(parameter int PWW = 6) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic [1:0] req_kind,
  input logic [PWW-1:0] pw_space,
  input logic rsp_accept,
  input logic rsp_complete,
  input logic rsp_retry,
  input logic [8:0] rsp_cause,
  input logic fwd_valid
);
  // R1
  resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_accept, rsp_complete, rsp_retry}));
  // R1
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_accept || rsp_complete || rsp_retry));
  // R1
  retry_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_retry |-> (rsp_cause != 9'd0));
  // R2
  fwd_is_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (rsp_retry && rsp_cause[0]));
  // R7
  full_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cause[4] |-> !fwd_valid);
  // R6
  cpl_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_complete |-> (rsp_cause == 9'd0));
  // R11
  pw_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind[1] && (pw_space < 2) |=> rsp_retry && rsp_cause[8]);
endmodule

bind dly_retry_ctl dly_retry_ctl_chk #(.PWW(PWW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .pw_space(pw_space), .rsp_accept(rsp_accept), .rsp_complete(rsp_complete),
  .rsp_retry(rsp_retry), .rsp_cause(rsp_cause), .fwd_valid(fwd_valid)
);

// File: tb/dly_retry_ctl_bench.sv
module dly_retry_ctl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_lock = 0, lock_active = 0, tgt_bus_locked = 0;
  logic prefetch_discard = 0, posted_pending = 0, cpl_valid = 0;
  logic [1:0] req_kind = 0;
  logic [31:0] req_addr = 0;
  logic [3:0] req_cmd = 0;
  logic [5:0] pw_space = 0, accept_est = 0;
  logic rsp_accept, rsp_complete, rsp_retry, fwd_valid, fwd_write;
  logic [8:0] rsp_cause;
  logic [31:0] fwd_addr;
  logic [3:0] fwd_cmd;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  dly_retry_ctl u_dly_retry_ctl (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // exp_r: {accept, complete, retry}
  task automatic req(input string tag, input logic [1:0] k, input logic [31:0] a,
                     input logic [3:0] c, input logic [2:0] exp_r, input logic [8:0] exp_c,
                     input logic exp_f);
    @(negedge clk);
    req_valid = 1; req_kind = k; req_addr = a; req_cmd = c;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " rsp"}, {29'd0, rsp_accept, rsp_complete, rsp_retry}, {29'd0, exp_r});
    chk({tag, " cause"}, {23'd0, rsp_cause}, {23'd0, exp_c});
    chk({tag, " fwd"}, {31'd0, fwd_valid}, {31'd0, exp_f});
    if (exp_f) chk({tag, " fwd_addr"}, fwd_addr ^ {28'd0, fwd_cmd} ^ {31'd0, fwd_write} << 8,
                   a ^ {28'd0, c} ^ {31'd0, k[0]} << 8);
  endtask

  task automatic cpl();
    @(negedge clk); cpl_valid = 1;
    @(negedge clk); cpl_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 reset rsp", {29'd0, rsp_accept, rsp_complete, rsp_retry}, 0);
    chk("R13 reset fwd", {31'd0, fwd_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R13 after reset", {28'd0, rsp_accept, rsp_complete, rsp_retry, fwd_valid}, 0);

    // R11 R8 R9 posted sweep
    for (int sp = 0; sp < 5; sp++)
      for (int m = 0; m < 8; m++)
        for (int e = 15; e < 18; e++) begin
          logic lv, tv, sv;
          lock_active = m[0]; req_lock = m[1]; tgt_bus_locked = m[2];
          pw_space = 6'(sp); accept_est = 6'(e);
          lv = (m[0] && !m[1]) || (m[1] && m[2]);
          tv = (e > 16);
          sv = (sp < 2);
          if (!lv && !tv && !sv) req("R11 posted", 2'b10, 32'h100, 4'h7, 3'b100, 0, 0);
          else req("R11/R8/R9 posted", 2'b10, 32'h100, 4'h7, 3'b001,
                   {sv, 1'b0, tv, lv, 5'b0}, 0);
        end
    lock_active = 0; req_lock = 0; tgt_bus_locked = 0; accept_est = 0; pw_space = 8;

    req("R2 read A0", 2'b00, 32'hA0, 4'h6, 3'b001, 9'h001, 1);
    req("R3 read A0 pending", 2'b00, 32'hA0, 4'h6, 3'b001, 9'h002, 0);
    req("R2 write A1", 2'b01, 32'hA1, 4'h7, 3'b001, 9'h001, 1);
    req("R2 write A2", 2'b01, 32'hA2, 4'h7, 3'b001, 9'h001, 1);
    req("R2 read A3", 2'b00, 32'hA3, 4'h6, 3'b001, 9'h001, 1);
    req("R7 full", 2'b00, 32'hA4, 4'h6, 3'b001, 9'h010, 0);

    // R8 R9 R10 blockers with full queue
    for (int m = 0; m < 32; m++)
      for (int k = 0; k < 2; k++) begin
        logic lv, tv, dv;
        lock_active = m[0]; req_lock = m[1]; tgt_bus_locked = m[2];
        accept_est = m[3] ? 6'd17 : 6'd16; prefetch_discard = m[4];
        lv = (m[0] && !m[1]) || (m[1] && m[2]);
        tv = m[3];
        dv = m[4] && (k == 0);
        if (lv || tv || dv) req("R8/R9/R10 blocked", 2'(k), 32'hA9, 4'h6, 3'b001,
                                {1'b0, dv, tv, lv, 5'b0}, 0);
        else req("R7 full sweep", 2'(k), 32'hA9, 4'h6, 3'b001, 9'h010, 0);
      end
    lock_active = 0; req_lock = 0; tgt_bus_locked = 0; accept_est = 0; prefetch_discard = 0;

    cpl(); cpl();
    req("R4 A1 done not head", 2'b01, 32'hA1, 4'h7, 3'b001, 9'h004, 0);
    req("R12 A2 not yet done", 2'b01, 32'hA2, 4'h7, 3'b001, 9'h002, 0);
    posted_pending = 1;
    req("R5 read held by posted", 2'b00, 32'hA0, 4'h6, 3'b001, 9'h008, 0);
    posted_pending = 0;
    req("R6 read A0 complete", 2'b00, 32'hA0, 4'h6, 3'b010, 9'h000, 0);
    req("R6 A0 freed re-enter", 2'b00, 32'hA0, 4'h6, 3'b001, 9'h001, 1);
    posted_pending = 1;
    req("R5 write ignores posted", 2'b01, 32'hA1, 4'h7, 3'b010, 9'h000, 0);
    prefetch_discard = 1;
    req("R10 write ignores discard", 2'b01, 32'hA2, 4'h7, 3'b001, 9'h002, 0);
    prefetch_discard = 0; posted_pending = 0;
    req("R3 cmd differs new", 2'b01, 32'hA2, 4'h3, 3'b001, 9'h001, 1);
    cpl();
    req("R12 A2 complete", 2'b01, 32'hA2, 4'h7, 3'b010, 9'h000, 0);
    req("R12 A3 still pending", 2'b00, 32'hA3, 4'h6, 3'b001, 9'h002, 0);
    @(negedge clk);
    chk("R1 idle no rsp", {29'd0, rsp_accept, rsp_complete, rsp_retry}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule